// File: doc/BRIEF.md
# Dual-Radio Shared GPIO Bank Controller

This block drives a 12-pin general-purpose I/O bank that two radio channels share. Each radio has its own set of configuration registers: a per-bit mode select, a per-bit output enable, a manual output value, and four state-dependent output values. The state-dependent values are chosen by that radio's live transmit and receive activity. A single owner-select register, which only radio 0's register space holds, gives each pin to one radio. That radio then supplies the pin's mode, enable, manual value and state-dependent value.

Software writes registers over a plain register bus. Each write carries a data word and a bit mask, and only the masked bits change. A registered read port returns any register. It also returns the pin levels after a two-flop synchroniser, so software can confirm that a driven pin reached its expected level.

Top module: `fpgpio_dual_ctrl`

## Requirements
- R1: After reset every register reads 0. Both `pad_out` and `pad_oe` are 0, so every pin is an input owned by radio 0.
- R2: A write changes only the register bits whose `wr_mask` bit is 1. All other bits keep their old value.
- R3: For an owned pin, a mode bit of 0 (CTRL, address 1) outputs the manual bit (address 3). A mode bit of 1 outputs the state-dependent bit for the owner's current state.
- R4: The state is {tx_active[r], rx_active[r]}. 00 selects the idle value (address 4), 01 the receive value (address 5), 10 the transmit value (address 6) and 11 the full-duplex value (address 7).
- R5: `pad_oe` bit b equals the owner's direction bit (address 2). Both `pad_out` and `pad_oe` are registered, so they reflect register and state inputs one clock later.
- R6: Owner-select bit b (address 0 in radio 0's space) picks radio 0 when it is 0 and radio 1 when it is 1. Mode, direction, manual and state values, and the state itself, all come from the chosen radio.
- R7: Radio 1 has no owner-select register. A write to radio 1 at address 0 leaves the owner selection unchanged, and a read there returns 0.
- R8: Address 8 in either space returns the pin levels after a two-flop synchroniser, so a read sampled two or more clocks after a pin change sees it. Writes to address 8 are ignored.
- R9: Addresses 9 to 15 read as 0, and writes to them change nothing.
- R10: `rd_data` loads the addressed register on a clock edge where `rd_en` is 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register space of the write (0 = radio 0, 1 = radio 1) |
| wr_addr | input | 4 | Write address |
| wr_data | input | 12 | Write data |
| wr_mask | input | 12 | Bits of wr_data to apply |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Register space of the read |
| rd_addr | input | 4 | Read address |
| rd_data | output | 12 | Registered read data |
| tx_active | input | 2 | Transmit activity per radio |
| rx_active | input | 2 | Receive activity per radio |
| pad_in | input | 12 | Pin levels from the pads |
| pad_out | output | 12 | Registered pin output values |
| pad_oe | output | 12 | Registered pin output enables |

## Verification
The assertions assume that reset is held for at least one clock before operation. They also assume that bus writes and reads are single-cycle strobes whose address and mask are valid only while the strobe is high. The bench changes every input half a clock away from the active edge. It holds each strobe for exactly one edge and raises reset only at the start. The pin inputs are treated as asynchronous, so they are checked only through the synchronised readback after the two-flop delay.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_SRC     = 4'd0,
    A_CTRL    = 4'd1,
    A_DIR     = 4'd2,
    A_MAN     = 4'd3,
    A_AT_IDLE = 4'd4,
    A_AT_RX   = 4'd5,
    A_AT_TX   = 4'd6,
    A_AT_FDX  = 4'd7,
    A_PINS    = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RX   = 2'b01,
    ST_TX   = 2'b10,
    ST_FDX  = 2'b11
  } atr_state_e;

  localparam int N_STATES = 4;

  function automatic logic [31:0] apply_mask(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [31:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/fpg_sync2.sv
module fpg_sync2 #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fpg_radio_regs.sv
module fpg_radio_regs
  import fpg_pkg::*;
#(
  parameter int W       = 12,
  parameter bit HAS_SRC = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [W-1:0]               wr_data,
  input  logic [W-1:0]               wr_mask,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [W-1:0]               pins_sync,
  output logic [W-1:0]               src_q,
  output logic [W-1:0]               ctrl_q,
  output logic [W-1:0]               dir_q,
  output logic [W-1:0]               man_q,
  output logic [N_STATES-1:0][W-1:0] atr_q,
  output logic [W-1:0]               rd_val
);
  function automatic logic [W-1:0] upd(input logic [W-1:0] o);
    return W'(apply_mask(32'(o), 32'(wr_data), 32'(wr_mask)));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dir_q  <= '0;
      man_q  <= '0;
      atr_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:    ctrl_q   <= upd(ctrl_q);
        A_DIR:     dir_q    <= upd(dir_q);
        A_MAN:     man_q    <= upd(man_q);
        A_AT_IDLE: atr_q[0] <= upd(atr_q[0]);
        A_AT_RX:   atr_q[1] <= upd(atr_q[1]);
        A_AT_TX:   atr_q[2] <= upd(atr_q[2]);
        A_AT_FDX:  atr_q[3] <= upd(atr_q[3]);
        default: ;
      endcase
    end
  end

  generate
    if (HAS_SRC) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else if (wr_en && wr_addr == A_SRC) src_q <= upd(src_q);
      end
    end else begin : g_nosrc
      assign src_q = '0;
    end
  endgenerate

  always_comb begin
    case (rd_addr)
      A_SRC:     rd_val = src_q;
      A_CTRL:    rd_val = ctrl_q;
      A_DIR:     rd_val = dir_q;
      A_MAN:     rd_val = man_q;
      A_AT_IDLE: rd_val = atr_q[0];
      A_AT_RX:   rd_val = atr_q[1];
      A_AT_TX:   rd_val = atr_q[2];
      A_AT_FDX:  rd_val = atr_q[3];
      A_PINS:    rd_val = pins_sync;
      default:   rd_val = '0;
    endcase
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_DIR) |=>
      ((dir_q & ~$past(wr_mask)) == ($past(dir_q) & ~$past(wr_mask)))) // R2
    else $error("unmasked direction bits changed");

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(ctrl_q) && $stable(dir_q) && $stable(man_q) && $stable(atr_q))) // R2
    else $error("register changed without a write");
endmodule

// File: rtl/fpg_atr_pick.sv
module fpg_atr_pick
  import fpg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                       tx,
  input  logic                       rx,
  input  logic [W-1:0]               ctrl,
  input  logic [W-1:0]               man,
  input  logic [N_STATES-1:0][W-1:0] atr,
  output logic [W-1:0]               val
);
  atr_state_e st;
  logic [W-1:0] atr_cur;

  assign st = atr_state_e'({tx, rx});

  always_comb begin
    case (st)
      ST_IDLE: atr_cur = atr[0];
      ST_RX:   atr_cur = atr[1];
      ST_TX:   atr_cur = atr[2];
      default: atr_cur = atr[3];
    endcase
  end

  assign val = (ctrl & atr_cur) | (~ctrl & man);
endmodule

// File: rtl/fpg_pin_mux.sv
module fpg_pin_mux #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] owner,
  input  logic [W-1:0] val0,
  input  logic [W-1:0] val1,
  input  logic [W-1:0] dir0,
  input  logic [W-1:0] dir1,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] nxt_out, nxt_oe;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign nxt_out[b] = owner[b] ? val1[b] : val0[b];
    assign nxt_oe[b]  = owner[b] ? dir1[b] : dir0[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  AST_OE_RESET: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0)) // R1
    else $error("pads not released by reset");
endmodule

// File: rtl/fpgpio_dual_ctrl.sv
module fpgpio_dual_ctrl
  import fpg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      wr_mask,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [1:0]        tx_active,
  input  logic [1:0]        rx_active,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);
  localparam int N_RADIO = 2;

  logic [W-1:0] pins_sync;
  logic [W-1:0] src_a  [N_RADIO];
  logic [W-1:0] ctrl_a [N_RADIO];
  logic [W-1:0] dir_a  [N_RADIO];
  logic [W-1:0] man_a  [N_RADIO];
  logic [N_STATES-1:0][W-1:0] atr_a [N_RADIO];
  logic [W-1:0] val_a  [N_RADIO];
  logic [W-1:0] rdv_a  [N_RADIO];
  logic [W-1:0] owner;

  fpg_sync2 #(.W(W)) sync_i (.clk(clk), .rst(rst), .d(pad_in), .q(pins_sync));

  for (genvar r = 0; r < N_RADIO; r++) begin : g_radio
    fpg_radio_regs #(.W(W), .HAS_SRC(r == 0)) regs_i (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && (wr_sel == 1'(r))),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .rd_addr(rd_addr), .pins_sync(pins_sync),
      .src_q(src_a[r]), .ctrl_q(ctrl_a[r]), .dir_q(dir_a[r]),
      .man_q(man_a[r]), .atr_q(atr_a[r]), .rd_val(rdv_a[r])
    );

    fpg_atr_pick #(.W(W)) pick_i (
      .tx(tx_active[r]), .rx(rx_active[r]),
      .ctrl(ctrl_a[r]), .man(man_a[r]), .atr(atr_a[r]),
      .val(val_a[r])
    );
  end

  // radio 1 ties its owner-select to zero, so the OR is radio 0's register
  assign owner = src_a[0] | src_a[1];

  fpg_pin_mux #(.W(W)) mux_i (
    .clk(clk), .rst(rst), .owner(owner),
    .val0(val_a[0]), .val1(val_a[1]),
    .dir0(dir_a[0]), .dir1(dir_a[1]),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel ? rdv_a[1] : rdv_a[0];
  end

  AST_SRC_RADIO1_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> $stable(owner)) // R7
    else $error("radio 1 write altered owner select");

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr > 4'd8) |=> (rd_data == '0)) // R9
    else $error("unmapped read returned nonzero");

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)) // R10
    else $error("read data changed without a read");
endmodule

// File: tb/fpgpio_dual_ctrl_tb.sv
module fpgpio_dual_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0, wr_mask = '0;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic [1:0]  tx_active = '0, rx_active = '0;
  logic [11:0] pad_in = '0;
  logic [11:0] pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpgpio_dual_ctrl dut_i (.*);

  typedef struct packed {
    logic [11:0] ctrl, dir, man, a0, a1, a2, a3;
    logic        tx, rx;
    logic [11:0] e_out, e_oe;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{12'h000, 12'hFFF, 12'hA5A, 12'h111, 12'h222, 12'h444, 12'h888, 1'b0, 1'b0, 12'hA5A, 12'hFFF},
    '{12'hFFF, 12'hFFF, 12'h000, 12'h111, 12'h222, 12'h444, 12'h888, 1'b0, 1'b0, 12'h111, 12'hFFF},
    '{12'hFFF, 12'hFFF, 12'h000, 12'h111, 12'h222, 12'h444, 12'h888, 1'b0, 1'b1, 12'h222, 12'hFFF},
    '{12'hFFF, 12'hFFF, 12'h000, 12'h111, 12'h222, 12'h444, 12'h888, 1'b1, 1'b0, 12'h444, 12'hFFF},
    '{12'hFFF, 12'hFFF, 12'h000, 12'h111, 12'h222, 12'h444, 12'h888, 1'b1, 1'b1, 12'h888, 12'hFFF},
    '{12'hF0F, 12'h0F0, 12'h0F0, 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0, 1'b0, 12'hFFF, 12'h0F0},
    '{12'h0F0, 12'h3C3, 12'h123, 12'h0AB, 12'h0CD, 12'h0EF, 12'h0FE, 1'b1, 1'b0, 12'h1E3, 12'h3C3}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] a, input logic [11:0] d, input logic [11:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [3:0] a, output logic [11:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 12'h000);
    chk("R1 pad_out", pad_out, 12'h000);
    rd(1'b0, 4'd2, v); chk("R1 dir", v, 12'h000);
    rd(1'b0, 4'd0, v); chk("R1 src", v, 12'h000);

    // R3 R4 R5 table walk on radio 0
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_active = {1'b0, TBL[i].tx}; rx_active = {1'b0, TBL[i].rx};
      wr(1'b0, 4'd1, TBL[i].ctrl, 12'hFFF);
      wr(1'b0, 4'd2, TBL[i].dir,  12'hFFF);
      wr(1'b0, 4'd3, TBL[i].man,  12'hFFF);
      wr(1'b0, 4'd4, TBL[i].a0,   12'hFFF);
      wr(1'b0, 4'd5, TBL[i].a1,   12'hFFF);
      wr(1'b0, 4'd6, TBL[i].a2,   12'hFFF);
      wr(1'b0, 4'd7, TBL[i].a3,   12'hFFF);
      @(negedge clk);
      chk($sformatf("R3 R4 out vec %0d", i), pad_out, TBL[i].e_out);
      chk($sformatf("R5 oe vec %0d", i), pad_oe, TBL[i].e_oe);
    end

    // R2 masked write
    wr(1'b0, 4'd2, 12'hFFF, 12'h800);
    rd(1'b0, 4'd2, v); chk("R2 masked dir", v, 12'hBC3);
    rd(1'b0, 4'd6, v); chk("R10 read tx value", v, 12'h0EF);

    // R6 owner select
    tx_active = '0; rx_active = '0;
    wr(1'b0, 4'd1, 12'h000, 12'hFFF);
    wr(1'b0, 4'd2, 12'h000, 12'hFFF);
    wr(1'b0, 4'd3, 12'h000, 12'hFFF);
    wr(1'b1, 4'd1, 12'h000, 12'hFFF);
    wr(1'b1, 4'd2, 12'hFFF, 12'hFFF);
    wr(1'b1, 4'd3, 12'hABC, 12'hFFF);
    wr(1'b0, 4'd0, 12'hF00, 12'hFFF);
    @(negedge clk);
    chk("R6 out split", pad_out, 12'hA00);
    chk("R6 oe split", pad_oe, 12'hF00);

    // R7 radio 1 has no owner select
    wr(1'b1, 4'd0, 12'hFFF, 12'hFFF);
    @(negedge clk);
    chk("R7 oe unchanged", pad_oe, 12'hF00);
    rd(1'b1, 4'd0, v); chk("R7 radio1 src reads 0", v, 12'h000);
    rd(1'b0, 4'd0, v); chk("R7 radio0 src kept", v, 12'hF00);

    // R6 R4 owner state drives owned pins
    wr(1'b1, 4'd6, 12'hFFF, 12'hFFF);
    wr(1'b1, 4'd1, 12'hFFF, 12'hFFF);
    tx_active = 2'b10; rx_active = 2'b00;
    @(negedge clk);
    chk("R6 radio1 tx state", pad_out, 12'hF00);
    tx_active = 2'b01; rx_active = 2'b01;
    @(negedge clk); @(negedge clk);
    chk("R6 radio0 state no effect on radio1 pins", pad_out, 12'h000);

    // R8 synchronised readback
    @(negedge clk);
    pad_in = 12'h5A5;
    @(posedge clk);
    rd(1'b0, 4'd8, v); chk("R8 sync not yet", v, 12'h000);
    rd(1'b0, 4'd8, v); chk("R8 sync radio0", v, 12'h5A5);
    rd(1'b1, 4'd8, v); chk("R8 sync radio1", v, 12'h5A5);
    wr(1'b0, 4'd8, 12'h000, 12'hFFF);
    rd(1'b0, 4'd8, v); chk("R8 write ignored", v, 12'h5A5);

    // R9 unmapped addresses
    wr(1'b0, 4'd12, 12'hFFF, 12'hFFF);
    rd(1'b0, 4'd12, v); chk("R9 unmapped read", v, 12'h000);
    rd(1'b0, 4'd1, v);  chk("R9 ctrl untouched", v, 12'h000);
    @(negedge clk);
    chk("R9 pads untouched", pad_out, 12'h000);
    chk("R9 oe untouched", pad_oe, 12'hF00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule